// File: doc/BRIEF.md
# Block Sync-Header Token Framer

This block is the receive-side framing parser for a single lane of a 128b/130b link, after alignment and descrambling. Every block reaches it as a 2-bit sync header on a strobe of its own, followed by sixteen payload bytes, one per clock. The block decides whether each block carries data or an ordered set. Ordered-set blocks never reach the token logic. Data blocks are walked token by token, and the packet bytes come out with start, end and packet-kind markers.

Packets have no closing delimiter. A transaction packet's end is found from the dword length carried in its start token. A link packet is always eight bytes. The byte count carries across block boundaries, including across ordered-set blocks that arrive in the middle of a packet. Filler zero bytes are discarded. A nullify marker is raised when a packet is revoked, and a stream-end marker when the stream pauses. A framing-error pulse covers bad headers, unknown tokens and data that arrives before the stream has been opened. After a framing error, a new start-of-stream ordered set is needed.

Top module: `sh_token_framer`

## Requirements
- R1: During and after reset all outputs are 0 and the stream is closed, so the first data block is refused.
- R2: Sync header 10b marks a data block and 01b an ordered-set block. Header 00b or 11b pulses `frame_err`, closes the stream and drops that block's payload.
- R3: An ordered-set block whose first payload byte is E1h opens the stream. A data-block header while the stream is closed pulses `frame_err`, and that block's payload produces no output.
- R4: A 00h byte in token position is logical idle and produces no output.
- R5: A token byte F0h starts a link packet of exactly 8 bytes. They are emitted with `pkt_kind`=1, `pkt_sop` on the first byte and `pkt_eop` on the eighth.
- R6: A token byte with low nibble Fh (other than 1Fh) starts a transaction packet with `pkt_kind`=0. Its length in dwords is {byte0[7:4], byte1[6:0]}, it counts the whole packet, and `pkt_eop` marks byte 4*length. A length of 0 pulses `frame_err` at the second byte.
- R7: A packet's byte count continues across data-block boundaries and across intervening ordered-set blocks. Ordered-set payload and bytes inside a packet body are never parsed as tokens.
- R8: A C0h token right after the last byte of a transaction packet pulses `pkt_nullify` and consumes 4 bytes. A C0h token anywhere else is a framing error.
- R9: A 1Fh token pulses `stream_end`, and the rest of that block is ignored. The next data block is parsed from its first byte.
- R10: Any other token byte pulses `frame_err`, drops the rest of the block and closes the stream.
- R11: Every output responds exactly one clock after the header or byte that caused it. At most one of `pkt_vld`, `pkt_nullify`, `stream_end` and `frame_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_vld | input | 1 | Sync header present this cycle (starts a block) |
| hdr | input | 2 | Sync header value |
| byte_vld | input | 1 | Payload byte present this cycle (ignored when hdr_vld is high) |
| byte_in | input | 8 | Payload byte |
| pkt_vld | output | 1 | Packet byte valid |
| pkt_byte | output | 8 | Packet byte (0 when not valid) |
| pkt_sop | output | 1 | First byte of a packet |
| pkt_eop | output | 1 | Last byte of a packet |
| pkt_kind | output | 1 | 1 = link packet, 0 = transaction packet |
| pkt_nullify | output | 1 | Preceding transaction packet revoked |
| stream_end | output | 1 | Stream pause or end token seen |
| frame_err | output | 1 | Framing error pulse |

## Verification
The stimulus runs the parser through a link packet inside a single block and another that straddles a block boundary. It also sends a short transaction packet split by a skip ordered-set block, and a longer one spread over three blocks whose body holds C0h, 1Fh and F0h. These separate true length counting from token matching inside the body. The revoke token is sent once straight after a packet end and once after an idle byte, which separates the legal and illegal positions. Bad headers, early data blocks, an unknown token and a zero length each check that the stream closes, that the rest of the block is dropped and that a new start-of-stream set reopens it.

// File: rtl/sh_framer_pkg.sv
package sh_framer_pkg;

  localparam int LEN_W = 11;
  localparam int CNT_W = LEN_W + 2;

  localparam logic [1:0] SH_DATA = 2'b10;
  localparam logic [1:0] SH_OS   = 2'b01;

  localparam logic [7:0] B_IDLE = 8'h00;
  localparam logic [7:0] B_LINK = 8'hF0;
  localparam logic [7:0] B_BAD  = 8'hC0;
  localparam logic [7:0] B_EOS  = 8'h1F;
  localparam logic [7:0] B_SDS  = 8'hE1;

  typedef enum logic [1:0] {BK_NONE, BK_DATA, BK_OS, BK_DROP} blk_kind_e;
  typedef enum logic [2:0] {WK_TOKEN, WK_TLPLEN, WK_BODY, WK_EAT, WK_PARK} walk_e;
  typedef enum logic [2:0] {TC_IDLE, TC_TLP, TC_LINK, TC_BAD, TC_EOS, TC_UNK} tok_e;

  function automatic tok_e tok_class(input logic [7:0] b);
    if (b == B_IDLE)       return TC_IDLE;
    else if (b == B_LINK)  return TC_LINK;
    else if (b == B_BAD)   return TC_BAD;
    else if (b == B_EOS)   return TC_EOS;
    else if (b[3:0] == 4'hF) return TC_TLP;
    else                   return TC_UNK;
  endfunction

  // total bytes of a transaction packet: dword count times four
  function automatic logic [CNT_W-1:0] tlp_total(input logic [3:0] hi, input logic [6:0] lo);
    return {hi, lo, 2'b00};
  endfunction

endpackage

// File: rtl/sh_block_tracker.sv
module sh_block_tracker
  import sh_framer_pkg::*;
#(
  parameter int BLK_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_vld,
  input  logic [1:0] hdr,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       tok_err,
  output logic       data_vld,
  output logic       os_byte,
  output logic       hdr_err,
  output logic       blk_start,
  output logic       stream_open
);
  localparam int IDX_W = $clog2(BLK_BYTES + 1);
  localparam logic [IDX_W-1:0] FULL = IDX_W'(BLK_BYTES);

  blk_kind_e        kind;
  logic [IDX_W-1:0] left;
  logic             taking;
  logic             hdr_bad;
  logic             hdr_early;
  logic             sds_hit;

  always_comb begin
    hdr_bad   = hdr_vld && (hdr != SH_DATA) && (hdr != SH_OS);
    hdr_early = hdr_vld && (hdr == SH_DATA) && !stream_open;
    hdr_err   = hdr_bad || hdr_early;
    blk_start = hdr_vld;
    taking    = byte_vld && !hdr_vld && (left != '0);
    data_vld  = taking && (kind == BK_DATA);
    os_byte   = taking && (kind == BK_OS);
    sds_hit   = os_byte && (left == FULL) && (byte_in == B_SDS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind        <= BK_NONE;
      left        <= '0;
      stream_open <= 1'b0;
    end else begin
      if (hdr_vld) begin
        left <= FULL;
        if (hdr_err)              kind <= BK_DROP;
        else if (hdr == SH_DATA)  kind <= BK_DATA;
        else                      kind <= BK_OS;
      end else if (taking) begin
        left <= left - 1'b1;
        if (tok_err) kind <= BK_DROP;
      end
      if (hdr_err || tok_err) stream_open <= 1'b0;
      else if (sds_hit)       stream_open <= 1'b1;
    end
  end

endmodule

// File: rtl/sh_token_walker.sv
module sh_token_walker
  import sh_framer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_vld,
  input  logic [7:0] byte_in,
  input  logic       blk_start,
  input  logic       hdr_err,
  output logic       tok_err,
  output logic       idle_seen,
  output logic       pkt_vld,
  output logic [7:0] pkt_byte,
  output logic       pkt_sop,
  output logic       pkt_eop,
  output logic       pkt_kind,
  output logic       pkt_nullify,
  output logic       stream_end,
  output logic       frame_err
);
  localparam logic [CNT_W-1:0] LINK_REST = CNT_W'(7);
  localparam logic [CNT_W-1:0] BAD_REST  = CNT_W'(3);

  walk_e            st, st_n;
  logic [CNT_W-1:0] rem, rem_n;
  logic             kind_q, kind_n;
  logic [3:0]       hi_q, hi_n;
  logic             after_q, after_n;
  logic             emit, sop, eop, null_now, eos_now;
  logic [CNT_W-1:0] total;

  always_comb begin
    st_n = st; rem_n = rem; kind_n = kind_q; hi_n = hi_q; after_n = after_q;
    emit = 1'b0; sop = 1'b0; eop = 1'b0; null_now = 1'b0; eos_now = 1'b0;
    tok_err = 1'b0; idle_seen = 1'b0;
    total = tlp_total(hi_q, byte_in[6:0]);
    if (hdr_err) begin
      st_n = WK_TOKEN;
      after_n = 1'b0;
    end else if (blk_start) begin
      if (st == WK_PARK) st_n = WK_TOKEN;
    end else if (data_vld) begin
      unique case (st)
        WK_TOKEN: begin
          after_n = 1'b0;
          unique case (tok_class(byte_in))
            TC_IDLE: idle_seen = 1'b1;
            TC_LINK: begin
              emit = 1'b1; sop = 1'b1; kind_n = 1'b1;
              rem_n = LINK_REST; st_n = WK_BODY;
            end
            TC_TLP: begin
              emit = 1'b1; sop = 1'b1; kind_n = 1'b0;
              hi_n = byte_in[7:4]; st_n = WK_TLPLEN;
            end
            TC_BAD: begin
              if (after_q) begin
                null_now = 1'b1; rem_n = BAD_REST; st_n = WK_EAT;
              end else begin
                tok_err = 1'b1;
              end
            end
            TC_EOS: begin
              eos_now = 1'b1; st_n = WK_PARK;
            end
            default: tok_err = 1'b1;
          endcase
        end
        WK_TLPLEN: begin
          if (total == '0) begin
            tok_err = 1'b1;
          end else begin
            emit = 1'b1; rem_n = total - CNT_W'(2); st_n = WK_BODY;
          end
        end
        WK_BODY: begin
          emit = 1'b1;
          rem_n = rem - 1'b1;
          if (rem == CNT_W'(1)) begin
            eop = 1'b1; st_n = WK_TOKEN; after_n = !kind_q;
          end
        end
        WK_EAT: begin
          rem_n = rem - 1'b1;
          if (rem == CNT_W'(1)) st_n = WK_TOKEN;
        end
        default: ;
      endcase
      if (tok_err) begin
        st_n = WK_TOKEN;
        after_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= WK_TOKEN; rem <= '0; kind_q <= 1'b0; hi_q <= '0; after_q <= 1'b0;
      pkt_vld <= 1'b0; pkt_byte <= '0; pkt_sop <= 1'b0; pkt_eop <= 1'b0;
      pkt_kind <= 1'b0; pkt_nullify <= 1'b0; stream_end <= 1'b0; frame_err <= 1'b0;
    end else begin
      st <= st_n; rem <= rem_n; kind_q <= kind_n; hi_q <= hi_n; after_q <= after_n;
      pkt_vld     <= emit;
      pkt_byte    <= emit ? byte_in : 8'h00;
      pkt_sop     <= sop;
      pkt_eop     <= eop;
      pkt_kind    <= emit & kind_n;
      pkt_nullify <= null_now;
      stream_end  <= eos_now;
      frame_err   <= tok_err | hdr_err;
    end
  end

endmodule

// File: rtl/sh_token_framer.sv
module sh_token_framer
  import sh_framer_pkg::*;
#(
  parameter int BLK_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_vld,
  input  logic [1:0] hdr,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       pkt_vld,
  output logic [7:0] pkt_byte,
  output logic       pkt_sop,
  output logic       pkt_eop,
  output logic       pkt_kind,
  output logic       pkt_nullify,
  output logic       stream_end,
  output logic       frame_err
);
  logic data_vld, os_byte, hdr_err, blk_start, stream_open, tok_err, idle_seen;

  sh_block_tracker #(.BLK_BYTES(BLK_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr(hdr),
    .byte_vld(byte_vld), .byte_in(byte_in), .tok_err(tok_err),
    .data_vld(data_vld), .os_byte(os_byte), .hdr_err(hdr_err),
    .blk_start(blk_start), .stream_open(stream_open)
  );

  sh_token_walker u_walk (
    .clk(clk), .rst_n(rst_n), .data_vld(data_vld), .byte_in(byte_in),
    .blk_start(blk_start), .hdr_err(hdr_err), .tok_err(tok_err),
    .idle_seen(idle_seen), .pkt_vld(pkt_vld), .pkt_byte(pkt_byte),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_kind(pkt_kind),
    .pkt_nullify(pkt_nullify), .stream_end(stream_end), .frame_err(frame_err)
  );

endmodule

// File: rtl/sh_framer_chk.sv
module sh_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hdr_vld,
  input logic [1:0] hdr,
  input logic       byte_vld,
  input logic [7:0] byte_in,
  input logic       pkt_vld,
  input logic       pkt_sop,
  input logic       pkt_eop,
  input logic       pkt_nullify,
  input logic       stream_end,
  input logic       frame_err,
  input logic       idle_seen,
  input logic       os_byte,
  input logic       stream_open
);
  // R2
  bad_hdr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && (hdr == 2'b00 || hdr == 2'b11) |=> frame_err);
  // R3
  early_data_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && hdr == 2'b10 && !stream_open |=> frame_err);
  // R4
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_seen |=> !pkt_vld);
  // R5
  markers_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sop || pkt_eop) |-> pkt_vld);
  // R7
  os_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_byte |=> !pkt_vld);
  // R8
  nullify_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_nullify |-> $past(byte_vld && !hdr_vld && byte_in == 8'hC0));
  // R9
  eos_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stream_end |-> $past(byte_vld && !hdr_vld && byte_in == 8'h1F));
  // R11
  byte_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_vld |-> $past(byte_vld && !hdr_vld));
  // R11
  exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_vld, pkt_nullify, stream_end, frame_err}));
endmodule

bind sh_token_framer sh_framer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr(hdr),
  .byte_vld(byte_vld), .byte_in(byte_in), .pkt_vld(pkt_vld),
  .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_nullify(pkt_nullify),
  .stream_end(stream_end), .frame_err(frame_err), .idle_seen(idle_seen),
  .os_byte(os_byte), .stream_open(stream_open)
);

// File: tb/test_sh_token_framer.sv
`timescale 1ns/1ps
module test_sh_token_framer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, hdr_vld, byte_vld;
  logic [1:0] hdr;
  logic [7:0] byte_in;
  logic       pkt_vld, pkt_sop, pkt_eop, pkt_kind, pkt_nullify, stream_end, frame_err;
  logic [7:0] pkt_byte;

  sh_token_framer i_sh_token_framer (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr(hdr),
    .byte_vld(byte_vld), .byte_in(byte_in), .pkt_vld(pkt_vld),
    .pkt_byte(pkt_byte), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
    .pkt_kind(pkt_kind), .pkt_nullify(pkt_nullify),
    .stream_end(stream_end), .frame_err(frame_err)
  );

  int    checks = 0, fails = 0;
  string req = "R1";

  // reference model state
  bit m_open = 0;
  int m_blk = 0;      // 0 none, 1 data, 2 ordered set, 3 dropped
  int m_left = 0;
  int m_mode = 0;     // 0 token, 1 length byte, 2 body, 3 eat, 4 park
  int m_rem = 0;
  bit m_link = 0;
  int m_hi = 0;
  bit m_after = 0;
  bit e_vld, e_sop, e_eop, e_kind, e_nul, e_eos, e_err;
  logic [7:0] e_byte;

  task automatic m_fail_stream();
    e_err = 1; m_open = 0; m_blk = 3; m_mode = 0; m_after = 0;
  endtask

  task automatic m_walk(input logic [7:0] b);
    int d;
    case (m_mode)
      0: begin
        if (b == 8'h00) m_after = 0;
        else if (b == 8'hF0) begin
          e_vld = 1; e_byte = b; e_sop = 1; e_kind = 1;
          m_link = 1; m_rem = 7; m_mode = 2; m_after = 0;
        end else if (b == 8'hC0) begin
          if (m_after) begin e_nul = 1; m_rem = 3; m_mode = 3; m_after = 0; end
          else m_fail_stream();
        end else if (b == 8'h1F) begin
          e_eos = 1; m_mode = 4; m_after = 0;
        end else if (b[3:0] == 4'hF) begin
          e_vld = 1; e_byte = b; e_sop = 1; e_kind = 0;
          m_link = 0; m_hi = int'(b[7:4]); m_mode = 1; m_after = 0;
        end else m_fail_stream();
      end
      1: begin
        d = (m_hi * 128 + int'(b[6:0])) * 4;
        if (d == 0) m_fail_stream();
        else begin e_vld = 1; e_byte = b; e_kind = 0; m_rem = d - 2; m_mode = 2; end
      end
      2: begin
        e_vld = 1; e_byte = b; e_kind = m_link;
        if (m_rem == 1) begin e_eop = 1; m_mode = 0; m_after = !m_link; end
        m_rem--;
      end
      3: begin
        m_rem--;
        if (m_rem == 0) m_mode = 0;
      end
      default: ;
    endcase
  endtask

  task automatic m_step(input bit hv, input logic [1:0] h, input bit bv, input logic [7:0] b);
    bit first;
    e_vld = 0; e_byte = 0; e_sop = 0; e_eop = 0; e_kind = 0; e_nul = 0; e_eos = 0; e_err = 0;
    if (hv) begin
      m_left = 16;
      if ((h != 2'b10 && h != 2'b01) || (h == 2'b10 && !m_open)) m_fail_stream();
      else begin
        m_blk = (h == 2'b10) ? 1 : 2;
        if (m_mode == 4) m_mode = 0;
      end
    end else if (bv && m_left > 0) begin
      first = (m_left == 16);
      m_left--;
      if (m_blk == 2 && first && b == 8'hE1) m_open = 1;
      else if (m_blk == 1) m_walk(b);
    end
  endtask

  task automatic compare();
    logic [14:0] act, exp;
    act = {pkt_vld, pkt_byte, pkt_sop, pkt_eop, pkt_kind, pkt_nullify, stream_end, frame_err};
    exp = {e_vld, e_byte, e_sop, e_eop, e_kind, e_nul, e_eos, e_err};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic cyc(input bit hv, input logic [1:0] h, input bit bv, input logic [7:0] b);
    @(negedge clk);
    hdr_vld = hv; hdr = h; byte_vld = bv; byte_in = b;
    m_step(hv, h, bv, b);
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 2'b00, 0, 8'h00);
  endtask

  task automatic send_block(input logic [1:0] h, input logic [127:0] p);
    cyc(1, h, 0, 8'h00);
    for (int i = 0; i < 16; i++) cyc(0, 2'b00, 1, p[127 - 8*i -: 8]);
  endtask

  localparam logic [127:0] SDS  = 128'hE1555555_55555555_55555555_55555555;
  localparam logic [127:0] SKIP = 128'hAAAAAAAA_AAAAAAAA_AAAAAAAA_AAAAAAAA;

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; hdr_vld = 0; hdr = 0; byte_vld = 0; byte_in = 0;
    // R1: outputs stay zero through reset
    req = "R1";
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      e_vld = 0; e_byte = 0; e_sop = 0; e_eop = 0; e_kind = 0; e_nul = 0; e_eos = 0; e_err = 0;
      compare();
    end
    @(negedge clk); rst_n = 1;
    idle(2);
    // R1 / R3: stream closed after reset, data block refused
    send_block(2'b10, 128'h00F01122_33445566_77000000_00000000);
    // R3: opening set
    req = "R3";
    send_block(2'b01, SDS);
    idle(1);
    // R4 / R5: idle and a link packet inside one block
    req = "R5";
    send_block(2'b10, 128'h0000F0AC_01020304_5A5B0000_00000000);
    // R6 / R7: 3-dword transaction packet split by a skip block
    req = "R7";
    send_block(2'b10, 128'h00000000_00000000_0F03A1A2_A3A4A5A6);
    idle(2);
    send_block(2'b01, SKIP);
    // R8: revoke token right after the packet end
    req = "R8";
    send_block(2'b10, 128'hA7A8A9AA_C0C0C0C0_00000000_00000000);
    // R9: stream-end token parks the rest of the block
    req = "R9";
    send_block(2'b10, 128'h00001F80_9000F0C0_FF123456_78ABCDEF);
    // R6 / R7: 9-dword packet over three blocks, token bytes inside body
    req = "R6";
    send_block(2'b10, 128'h00000000_00000000_00000000_0F09B0B1);
    send_block(2'b10, 128'hC0C1C2C3_C4C5C6C7_C8C9CACB_CCCDCECF);
    send_block(2'b01, SKIP);
    send_block(2'b10, 128'h1F00F0E1_D2C3B4A5_96877869_5A4B3C2D);
    // R8: revoke token after an idle byte is an error
    req = "R8";
    send_block(2'b10, 128'h00C0C0C0_C0F01122_33445566_77000000);
    // R2: bad header; R3: data while closed
    req = "R2";
    send_block(2'b11, 128'hF0112233_44556677_00000000_00000000);
    req = "R3";
    send_block(2'b10, 128'hF0112233_44556677_00000000_00000000);
    send_block(2'b01, SDS);
    // R10: unknown token closes the stream, rest of block dropped
    req = "R10";
    send_block(2'b10, 128'h0000370F_03A1A2A3_A4A5A6A7_A8A9AAAB);
    send_block(2'b10, 128'h00000000_00000000_00000000_00000000);
    send_block(2'b01, SDS);
    // R6: zero length is a framing error
    req = "R6";
    send_block(2'b10, 128'h0F00F011_22334455_66770000_00000000);
    send_block(2'b01, SDS);
    // R2: header 00b while open
    req = "R2";
    send_block(2'b00, 128'h00000000_00000000_00000000_00000000);
    send_block(2'b01, SDS);
    // R7 / R11: link packet straddling a block boundary
    req = "R11";
    send_block(2'b10, 128'h00000000_00000000_00000000_F0112233);
    idle(3);
    send_block(2'b10, 128'h44556677_00000000_00000000_00000000);
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule